// File: doc/BRIEF.md
# Boundary-Scan Test Port for a Memory Device

This block is the boundary-scan test port of a memory device. A tester drives a test clock, a mode-select line and a serial data input, with an optional asynchronous reset. The block returns a serial data output and an output-enable for it. A 16-state controller walks through the usual capture, shift and update phases. A 3-bit instruction decides which data register sits between the serial input and output: a 1-bit bypass cell, a 32-bit identification word, or a 109-cell boundary chain.

The memory core sees two control lines. `core_hiz` asks the core to float every data output driver. `scan_drive` tells the pin ring to drive pins from the boundary update latches rather than from the core. Pin values reach the boundary chain as a plain parallel vector, and the update latches leave it the same way. Cell 108 is internal and has no pin behind it. Reserved instruction codes fall back to the bypass path and leave the core untouched.

Top module: `mem_tap_ctrl`

## Requirements
- R1: The controller follows the standard 16-state sequence on the rising edge of `tck` under `tms`. Five rising edges with `tms` high reach Test-Logic-Reset from any state. `trst_n` low forces Test-Logic-Reset at once, without a clock.
- R2: In Test-Logic-Reset the current instruction becomes IDCODE (001), so a data scan straight after reset returns the identification word, and `core_hiz` and `scan_drive` are low.
- R3: Capture-IR loads 001 into the instruction shift stage, and Shift-IR moves it out least significant bit first while shifting `tdi` in at the most significant bit.
- R4: The current instruction, and with it `core_hiz` and `scan_drive`, changes only on Update-IR or in reset. It holds through capture, shift and exit of an instruction scan.
- R5: IDCODE (001) selects a 32-bit word, captured in Capture-DR and shifted out bit 0 first. Its fields are: bits 31:29 revision 000, bits 28:12 device code (parameter, default 11010011010000111), bits 11:1 vendor code 00000110100, bit 0 = 1.
- R6: BYPASS (111) selects one cell that captures 0, so `tdi` appears on `tdo` one shift later.
- R7: The reserved codes 011, 101 and 110 act exactly like BYPASS and keep `core_hiz` and `scan_drive` low.
- R8: EXTEST (000), SAMPLE-Z (010) and SAMPLE/PRELOAD (100) select the 109-cell chain, with cell 0 nearest `tdo`. In Capture-DR, cell k takes `pin_sample[k]` for k below 108, and the internal cell 108 takes 0.
- R9: Update-DR with the chain selected copies cells 0 to 107 onto `bsc_update`. Under any other instruction, `bsc_update` keeps its value.
- R10: `core_hiz` is high exactly while the current instruction is SAMPLE-Z (010).
- R11: `scan_drive` is high exactly while the current instruction is EXTEST (000).
- R12: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is high only when the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| pin_sample | input | 108 | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| bsc_update | output | 108 | Boundary update latches toward the pin ring |
| scan_drive | output | 1 | Pins are driven from `bsc_update` |
| core_hiz | output | 1 | Request to float all memory data outputs |

## Verification
The assertions assume two things about the inputs. `tms` and `tdi` only move while `tck` is low. `pin_sample` holds steady across the rising edge that leaves Capture-DR. The bench drives `tms` and `tdi` just after each falling edge and changes `pin_sample` only while the controller idles in Run-Test/Idle, so both assumptions always hold. It samples `tdo` a little after the falling edge, so that each sampled bit is the one the next rising edge shifts away.

// File: rtl/mem_tap_pkg.sv
package mem_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST  = 3'b000,
        OP_IDCODE  = 3'b001,
        OP_SAMPZ   = 3'b010,
        OP_RSV3    = 3'b011,
        OP_PRELOAD = 3'b100,
        OP_RSV5    = 3'b101,
        OP_RSV6    = 3'b110,
        OP_BYPASS  = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {
        DR_BYP = 2'd0,
        DR_ID  = 2'd1,
        DR_BSC = 2'd2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    hiz;
        logic    drive;
    } op_decode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic op_decode_t op_decode(input tap_op_e op);
        op_decode_t r;
        r.sel   = DR_BYP;
        r.hiz   = 1'b0;
        r.drive = 1'b0;
        case (op)
            OP_EXTEST:  begin r.sel = DR_BSC; r.drive = 1'b1; end
            OP_IDCODE:  r.sel = DR_ID;
            OP_SAMPZ:   begin r.sel = DR_BSC; r.hiz = 1'b1; end
            OP_PRELOAD: r.sel = DR_BSC;
            default:    r.sel = DR_BYP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mem_tap_fsm.sv
module mem_tap_fsm
    import mem_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_next(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q.st <= ST_TLR;
        else         r_q    <= r_d;
    end

    assign state = r_q.st;

    // R1
    tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_TLR && tms) |=> (r_q.st == ST_TLR));

    // R1
    sel_ir_escape_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_SEL_IR && tms) |=> (r_q.st == ST_TLR));

endmodule

// File: rtl/mem_tap_ir.sv
module mem_tap_ir
    import mem_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_so,
    output op_decode_t dec
);

    localparam logic [IR_W-1:0] CAP_PAT = 3'b001;

    typedef struct packed {
        logic [IR_W-1:0] sh;
        tap_op_e         cur;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_TLR:    r_d.cur = OP_IDCODE;
            ST_CAP_IR: r_d.sh  = CAP_PAT;
            ST_SHF_IR: r_d.sh  = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.cur = tap_op_e'(r_q.sh);
            default:   r_d     = r_q;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.sh  <= CAP_PAT;
            r_q.cur <= OP_IDCODE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ir_so = r_q.sh[0];
    assign dec   = op_decode(r_q.cur);

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (r_q.sh == CAP_PAT));

    // R4
    ir_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(r_q.cur) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR));

    // R2
    ir_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (r_q.cur == OP_IDCODE));

endmodule

// File: rtl/mem_tap_idbyp.sv
module mem_tap_idbyp #(
    parameter logic [2:0]  REVISION  = 3'b000,
    parameter logic [16:0] DEVICE_ID = 17'b11010011010000111,
    parameter logic [10:0] VENDOR_ID = 11'b00000110100
) (
    input  logic tck,
    input  logic trst_n,
    input  logic id_cap,
    input  logic id_shf,
    input  logic byp_cap,
    input  logic byp_shf,
    input  logic tdi,
    output logic id_so,
    output logic byp_so
);

    localparam int          ID_W   = $bits(REVISION) + $bits(DEVICE_ID) + $bits(VENDOR_ID) + 1;
    localparam logic [ID_W-1:0] ID_VAL = {REVISION, DEVICE_ID, VENDOR_ID, 1'b1};

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            byp;
    } idb_regs_t;

    idb_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (id_cap)       r_d.id = ID_VAL;
        else if (id_shf)  r_d.id = {tdi, r_q.id[ID_W-1:1]};
        if (byp_cap)      r_d.byp = 1'b0;
        else if (byp_shf) r_d.byp = tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.id  <= ID_VAL;
            r_q.byp <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign id_so  = r_q.id[0];
    assign byp_so = r_q.byp;

    // R5
    id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        id_cap |=> (r_q.id == ID_VAL));

    // R6
    byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        byp_cap |=> (r_q.byp == 1'b0));

endmodule

// File: rtl/mem_tap_bscan.sv
module mem_tap_bscan #(
    parameter int LEN = 109
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           cap_en,
    input  logic           shf_en,
    input  logic           upd_en,
    input  logic           tdi,
    input  logic [LEN-2:0] pin_sample,
    output logic           bsc_so,
    output logic [LEN-2:0] upd_out
);

    localparam int NPIN = LEN - 1;

    typedef struct packed {
        logic [LEN-1:0]  chain;
        logic [NPIN-1:0] upd;
    } bsc_regs_t;

    bsc_regs_t r_d, r_q;

    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] shin_vec;

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        if (k == LEN - 1) begin : g_internal
            assign cap_vec[k]  = 1'b0;
            assign shin_vec[k] = tdi;
        end else begin : g_pin
            assign cap_vec[k]  = pin_sample[k];
            assign shin_vec[k] = r_q.chain[k+1];
        end
    end

    always_comb begin
        r_d = r_q;
        if (cap_en)      r_d.chain = cap_vec;
        else if (shf_en) r_d.chain = shin_vec;
        if (upd_en)      r_d.upd   = r_q.chain[NPIN-1:0];
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.chain <= '0;
            r_q.upd   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bsc_so  = r_q.chain[0];
    assign upd_out = r_q.upd;

    // R8
    bsc_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        cap_en |=> (r_q.chain[NPIN-1:0] == $past(pin_sample) && r_q.chain[LEN-1] == 1'b0));

    // R9
    bsc_upd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !upd_en |=> $stable(r_q.upd));

endmodule

// File: rtl/mem_tap_ctrl.sv
module mem_tap_ctrl
    import mem_tap_pkg::*;
#(
    parameter int          BSC_LEN   = 109,
    parameter logic [16:0] DEVICE_ID = 17'b11010011010000111,
    parameter logic [10:0] VENDOR_ID = 11'b00000110100,
    parameter logic [2:0]  REVISION  = 3'b000
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSC_LEN-2:0] pin_sample,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSC_LEN-2:0] bsc_update,
    output logic               scan_drive,
    output logic               core_hiz
);

    tap_state_e state;
    op_decode_t dec;
    logic       ir_so, id_so, byp_so, bsc_so;
    logic       sel_id, sel_byp, sel_bsc;
    logic       in_shf_dr, in_shf_ir, in_cap_dr, in_upd_dr;

    mem_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    mem_tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_so  (ir_so),
        .dec    (dec)
    );

    assign in_shf_dr = (state == ST_SHF_DR);
    assign in_shf_ir = (state == ST_SHF_IR);
    assign in_cap_dr = (state == ST_CAP_DR);
    assign in_upd_dr = (state == ST_UPD_DR);
    assign sel_id    = (dec.sel == DR_ID);
    assign sel_bsc   = (dec.sel == DR_BSC);
    assign sel_byp   = !sel_id && !sel_bsc;

    mem_tap_idbyp #(
        .REVISION  (REVISION),
        .DEVICE_ID (DEVICE_ID),
        .VENDOR_ID (VENDOR_ID)
    ) u_idbyp (
        .tck     (tck),
        .trst_n  (trst_n),
        .id_cap  (in_cap_dr && sel_id),
        .id_shf  (in_shf_dr && sel_id),
        .byp_cap (in_cap_dr && sel_byp),
        .byp_shf (in_shf_dr && sel_byp),
        .tdi     (tdi),
        .id_so   (id_so),
        .byp_so  (byp_so)
    );

    mem_tap_bscan #(
        .LEN (BSC_LEN)
    ) u_bscan (
        .tck        (tck),
        .trst_n     (trst_n),
        .cap_en     (in_cap_dr && sel_bsc),
        .shf_en     (in_shf_dr && sel_bsc),
        .upd_en     (in_upd_dr && sel_bsc),
        .tdi        (tdi),
        .pin_sample (pin_sample),
        .bsc_so     (bsc_so),
        .upd_out    (bsc_update)
    );

    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d    = o_q;
        o_d.en = in_shf_ir || in_shf_dr;
        if (in_shf_ir)    o_d.tdo = ir_so;
        else if (sel_id)  o_d.tdo = id_so;
        else if (sel_bsc) o_d.tdo = bsc_so;
        else              o_d.tdo = byp_so;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            o_q.tdo <= 1'b0;
            o_q.en  <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tdo        = o_q.tdo;
    assign tdo_en     = o_q.en;
    assign core_hiz   = dec.hiz;
    assign scan_drive = dec.drive;

    // R12
    tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SHF_IR || state == ST_SHF_DR));

    // R10
    hiz_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(core_hiz && scan_drive));

    // R2
    reset_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (!core_hiz && !scan_drive));

endmodule

// File: tb/mem_tap_ctrl_tb_top.sv
module mem_tap_ctrl_tb_top;

    localparam int LEN  = 109;
    localparam int NPIN = LEN - 1;
    localparam int SL   = 150;
    localparam logic [31:0] ID_EXP = 32'b000_11010011010000111_00000110100_1;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [NPIN-1:0] pin_sample = '0;
    logic tdo, tdo_en, scan_drive, core_hiz;
    logic [NPIN-1:0] bsc_update;

    int n_chk = 0;
    int n_err = 0;
    logic s_tdo, s_en;
    logic [159:0] sin, sout;
    logic en_all;

    always #10 tck = ~tck;

    mem_tap_ctrl dut_i (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .tdi        (tdi),
        .pin_sample (pin_sample),
        .tdo        (tdo),
        .tdo_en     (tdo_en),
        .bsc_update (bsc_update),
        .scan_drive (scan_drive),
        .core_hiz   (core_hiz)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        @(negedge tck);
        #2;
        tms   = m;
        tdi   = d;
        s_tdo = tdo;
        s_en  = tdo_en;
        @(posedge tck);
        #2;
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] capd,
                           output logic hiz_mid, output logic drv_mid);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i]);
            capd[i] = s_tdo;
        end
        hiz_mid = core_hiz;
        drv_mid = scan_drive;
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n);
        en_all = 1'b1;
        sout   = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, sin[i]);
            sout[i] = s_tdo;
            en_all  = en_all & s_en;
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [2:0]   capd;
        logic         hm, dm, hz0, dr0;
        logic [159:0] cap, exp;
        logic [NPIN-1:0] upd_before, upd_exp;
        int           len;

        #35;
        // R2 R12: state while reset is held
        check(!tdo_en && !core_hiz && !scan_drive, "R2", "reset outputs",
              {tdo_en, core_hiz, scan_drive}, 0);
        trst_n = 1'b1;
        tick(1, 0);
        tick(0, 0);

        // R2 R5: first data scan after reset reads the ID word
        sin = '0;
        scan_dr(32);
        check(sout[31:0] == ID_EXP, "R5", "id after reset", sout[31:0], ID_EXP);
        check(en_all, "R12", "tdo_en during shift-dr", en_all, 1);
        check(!tdo_en, "R12", "tdo_en idle", tdo_en, 0);

        // sweep all eight instruction codes
        for (int c = 0; c < 8; c++) begin
            hz0 = core_hiz;
            dr0 = scan_drive;
            for (int k = 0; k < NPIN; k++) pin_sample[k] = ((k + c) % 3 == 0);
            load_ir(c[2:0], capd, hm, dm);
            // R3
            check(capd == 3'b001, "R3", "ir capture pattern", capd, 3'b001);
            // R4
            check(hm == hz0 && dm == dr0, "R4", "outputs hold before update-ir",
                  {hm, dm}, {hz0, dr0});
            // R10
            check(core_hiz == (c == 2), "R10", "core_hiz per code", core_hiz, (c == 2));
            // R11
            check(scan_drive == (c == 0), "R11", "scan_drive per code", scan_drive, (c == 0));
            cap = '0;
            if (c == 1) begin
                len = 32;
                cap[31:0] = ID_EXP;
            end else if (c == 0 || c == 2 || c == 4) begin
                len = LEN;
                cap[NPIN-1:0] = pin_sample;
            end else begin
                len = 1;
            end
            for (int i = 0; i < 160; i++) sin[i] = (((i * 5) + (c * 3)) % 7) < 3;
            upd_before = bsc_update;
            scan_dr(SL);
            exp = '0;
            for (int t = 0; t < SL; t++) exp[t] = (t < len) ? cap[t] : sin[t - len];
            if (len == 1)
                // R6 R7: bypass path for 111 and reserved codes
                check(sout == exp, (c == 7) ? "R6" : "R7", "bypass stream", sout, exp);
            else if (len == 32)
                check(sout == exp, "R5", "id stream", sout, exp);
            else
                check(sout == exp, "R8", "boundary stream", sout, exp);
            if (len == LEN) begin
                for (int k = 0; k < NPIN; k++) upd_exp[k] = sin[SL - LEN + k];
                check(bsc_update == upd_exp, "R9", "update latches", bsc_update, upd_exp);
            end else begin
                check(bsc_update == upd_before, "R9", "update unchanged", bsc_update, upd_before);
            end
            // R7
            if (c == 3 || c == 5 || c == 6)
                check(!core_hiz && !scan_drive, "R7", "reserved leaves core", {core_hiz, scan_drive}, 0);
            check(en_all, "R12", "tdo_en in shift", en_all, 1);
        end

        // R1: five TMS-high clocks from Shift-DR reach reset, instruction back to IDCODE
        load_ir(3'b111, capd, hm, dm);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        tick(0, 0);
        sin = '0;
        scan_dr(32);
        check(sout[31:0] == ID_EXP, "R1", "five tms-high reset", sout[31:0], ID_EXP);

        // R1: asynchronous reset clears SAMPLE-Z without a clock
        load_ir(3'b010, capd, hm, dm);
        check(core_hiz, "R10", "sample-z loaded", core_hiz, 1);
        @(negedge tck);
        #5;
        trst_n = 1'b0;
        #1;
        check(!core_hiz, "R1", "async trst clears hiz", core_hiz, 0);
        #5;
        trst_n = 1'b1;
        tick(1, 0);
        tick(0, 0);
        check(!core_hiz && !scan_drive, "R2", "after trst", {core_hiz, scan_drive}, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule